// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C target that gives a bus master read and write access to a 64-entry byte register file. Its 7-bit bus address is one of two fixed values, picked by a strap input. A master writes by sending the address byte with the write flag, then a register index byte, then any number of data bytes. It reads by first setting the index with a write phase. It then sends a repeated start, or a stop followed by a start, and the address byte with the read flag. After that it clocks out bytes until it answers one with NACK and sends a stop.

The bus is only listened to while the chip-select input is high, so the same pins can be shared with a serial peripheral port. SCL and SDA are sampled in the system clock domain, which must run well above the bus rate; a 100 MHz system clock handles both standard (100 kHz) and fast (400 kHz) mode with a wide margin. SDA is returned as a drive-low enable for an open-drain pad outside the block. Clock stretching and general call are not handled.

Top module: `i2c_strap_regs`

## Requirements
- R1: After reset every register holds 0x00 and sdaDriveLow is 0.
- R2: With strapAlt high the block answers 7-bit address 0x1D (address bytes 0x3A write, 0x3B read) and gives no ACK to 0x53.
- R3: With strapAlt low the block answers 7-bit address 0x53 (address bytes 0xA6 write, 0xA7 read) and gives no ACK to 0x1D.
- R4: An address byte matching neither value gets no ACK; later bytes up to the next start are ignored and no register changes.
- R5: In a write, the byte after the address byte loads the register index; each following data byte is ACKed and stored at the index, which then advances by one.
- R6: In a read, the block returns the register at the index, MSB first, and advances the index; it goes on while the master ACKs and releases SDA after a NACK.
- R7: The index uses the low 6 bits of the index byte and wraps from 63 to 0 for both reads and writes.
- R8: While csHigh is low the block ignores SCL and SDA, never drives SDA, and changes no register.
- R9: A start seen mid-byte restarts address reception; a stop seen mid-byte returns to idle and writes nothing.
- R10: sdaDriveLow changes only while SCL is low and stays steady while SCL is high.
- R11: The index survives a stop followed by a new start, so a read can follow a separate index-setting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| csHigh | input | 1 | Enable: bus is honoured only while high |
| strapAlt | input | 1 | Address strap: high picks 0x1D, low picks 0x53 |
| sclIn | input | 1 | Bus clock level seen at the pad |
| sdaIn | input | 1 | Bus data level seen at the pad |
| sdaDriveLow | output | 1 | High pulls SDA low through the pad |

## Verification
The SDA checks assume the master keeps SCL low for more cycles than the synchronizer adds. They also assume it changes SDA only while SCL is low, except to form start and stop, and never while the target drives. The bench master holds each SCL phase for at least ten system clocks. It moves its own SDA a quarter bit after SCL falls, and it forms start and stop only while it has the line released. Chip select is changed only while the bus is idle.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_PTR, ST_PACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } state_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;    // drop SDA drive (start, stop, disabled)
    logic shiftIn;  // shift one received bit in
    logic setPtr;   // load index from received byte
    logic wrReg;    // store received byte, advance index
    logic loadTx;   // fetch register for transmit, advance index
    logic shiftTx;  // present next transmit bit
    logic ackOn;    // pull SDA low for ACK
    logic relDrv;   // release SDA
  } dp_ctrl_t;

endpackage

// File: rtl/i2c_strap_ctrl.sv
module i2c_strap_ctrl
  import i2c_strap_pkg::*;
#(
  parameter logic [6:0] ADDR_HI = 7'h1D,
  parameter logic [6:0] ADDR_LO = 7'h53
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     csHigh,
  input  logic     strapAlt,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  logic [7:0] rxNext,
  output dp_ctrl_t ctl,
  output logic     sdaBit
);

  logic [1:0] sclSync, sdaSync;
  logic       sclQ, sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ    <= sclSync[1];
      sdaQ    <= sdaSync[1];
    end
  end

  logic sclS, sclRise, sclFall, startSeen, stopSeen;
  assign sclS      = sclSync[1];
  assign sdaBit    = sdaSync[1];
  assign sclRise   = sclS & ~sclQ;
  assign sclFall   = ~sclS & sclQ;
  assign startSeen = sclS & sclQ & sdaQ & ~sdaBit;
  assign stopSeen  = sclS & sclQ & ~sdaQ & sdaBit;

  logic [6:0] myAddr;
  assign myAddr = strapAlt ? ADDR_HI : ADDR_LO;

  state_e     state, stateNxt;
  logic [2:0] bitCnt, bitCntNxt;
  logic       phase, phaseNxt, isRead, isReadNxt;

  always_comb begin
    stateNxt  = state;
    bitCntNxt = bitCnt;
    phaseNxt  = phase;
    isReadNxt = isRead;
    ctl       = '0;
    if (!csHigh) begin
      stateNxt  = ST_IDLE;
      bitCntNxt = '0;
      phaseNxt  = 1'b0;
      ctl.clear = 1'b1;
    end else if (startSeen) begin
      stateNxt  = ST_ADDR;
      bitCntNxt = '0;
      phaseNxt  = 1'b0;
      ctl.clear = 1'b1;
    end else if (stopSeen) begin
      stateNxt  = ST_IDLE;
      bitCntNxt = '0;
      phaseNxt  = 1'b0;
      ctl.clear = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDAT: if (sclRise) begin
          ctl.shiftIn = 1'b1;
          if (bitCnt == 3'd7) begin
            bitCntNxt = '0;
            if (state == ST_ADDR) begin
              if (rxNext[7:1] == myAddr) begin
                stateNxt  = ST_AACK;
                isReadNxt = rxNext[0];
              end else begin
                stateNxt = ST_IDLE;
              end
            end else if (state == ST_PTR) begin
              ctl.setPtr = 1'b1;
              stateNxt   = ST_PACK;
            end else begin
              ctl.wrReg = 1'b1;
              stateNxt  = ST_WACK;
            end
          end else begin
            bitCntNxt = bitCnt + 3'd1;
          end
        end
        ST_AACK, ST_PACK, ST_WACK: if (sclFall) begin
          if (!phase) begin
            ctl.ackOn = 1'b1;
            phaseNxt  = 1'b1;
          end else begin
            phaseNxt = 1'b0;
            if (state == ST_AACK && isRead) begin
              ctl.loadTx = 1'b1;
              stateNxt   = ST_RDAT;
            end else begin
              ctl.relDrv = 1'b1;
              stateNxt   = (state == ST_AACK) ? ST_PTR : ST_WDAT;
            end
          end
        end
        ST_RDAT: begin
          if (sclRise) begin
            if (bitCnt == 3'd7) begin
              bitCntNxt = '0;
              stateNxt  = ST_RACK;
            end else begin
              bitCntNxt = bitCnt + 3'd1;
            end
          end else if (sclFall) begin
            ctl.shiftTx = 1'b1;
          end
        end
        ST_RACK: begin
          if (sclFall) begin
            if (!phase) begin
              ctl.relDrv = 1'b1;
            end else begin
              phaseNxt   = 1'b0;
              ctl.loadTx = 1'b1;
              stateNxt   = ST_RDAT;
            end
          end else if (sclRise) begin
            if (!sdaBit) phaseNxt = 1'b1;
            else         stateNxt = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      phase  <= 1'b0;
      isRead <= 1'b0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
      phase  <= phaseNxt;
      isRead <= isReadNxt;
    end
  end

endmodule

// File: rtl/i2c_strap_dp.sv
module i2c_strap_dp
  import i2c_strap_pkg::*;
#(
  parameter int REG_COUNT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_ctrl_t   ctl,
  input  logic       sdaBit,
  output logic [7:0] rxNext,
  output logic       sdaDriveLow
);

  localparam int PTR_W = $clog2(REG_COUNT);

  logic [7:0]       regFile [REG_COUNT];
  logic [7:0]       shReg;
  logic [PTR_W-1:0] ptr;

  assign rxNext = {shReg[6:0], sdaBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
      shReg       <= '0;
      ptr         <= '0;
      sdaDriveLow <= 1'b0;
    end else begin
      if (ctl.shiftIn) shReg <= rxNext;
      if (ctl.setPtr)  ptr   <= rxNext[PTR_W-1:0];
      if (ctl.wrReg) begin
        regFile[ptr] <= rxNext;
        ptr          <= ptr + 1'b1;
      end
      if (ctl.loadTx) begin
        shReg <= regFile[ptr];
        ptr   <= ptr + 1'b1;
      end
      if (ctl.shiftTx) shReg <= {shReg[6:0], 1'b0};

      if (ctl.clear || ctl.relDrv) sdaDriveLow <= 1'b0;
      else if (ctl.ackOn)          sdaDriveLow <= 1'b1;
      else if (ctl.loadTx)         sdaDriveLow <= ~regFile[ptr][7];
      else if (ctl.shiftTx)        sdaDriveLow <= ~shReg[6];
    end
  end

endmodule

// File: rtl/i2c_strap_regs.sv
module i2c_strap_regs
  import i2c_strap_pkg::*;
#(
  parameter logic [6:0] ADDR_HI   = 7'h1D,
  parameter logic [6:0] ADDR_LO   = 7'h53,
  parameter int         REG_COUNT = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic csHigh,
  input  logic strapAlt,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow
);

  dp_ctrl_t   ctl;
  logic       sdaBit;
  logic [7:0] rxNext;

  i2c_strap_ctrl #(.ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_ctrl (
    .clk(clk), .rstN(rstN), .csHigh(csHigh), .strapAlt(strapAlt),
    .sclIn(sclIn), .sdaIn(sdaIn), .rxNext(rxNext), .ctl(ctl), .sdaBit(sdaBit)
  );

  i2c_strap_dp #(.REG_COUNT(REG_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaBit(sdaBit),
    .rxNext(rxNext), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2c_strap_regs_chk.sv
module i2c_strap_regs_chk (
  input logic clk,
  input logic rstN,
  input logic csHigh,
  input logic sclIn,
  input logic sdaDriveLow
);

  AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !sdaDriveLow);  // R1

  AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !csHigh |=> !sdaDriveLow);  // R8

  AST_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (csHigh && $past(csHigh) && sclIn && $past(sclIn)) |-> $stable(sdaDriveLow));  // R10

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn);  // R10

endmodule

bind i2c_strap_regs i2c_strap_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .csHigh(csHigh), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow)
);

// File: tb/tb_i2c_strap_regs.sv
module tb_i2c_strap_regs;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csHigh = 1'b1;
  logic strapAlt = 1'b1;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow;
  logic sdaBus;

  assign sdaBus = sdaM & ~sdaDriveLow;

  always #5 clk = ~clk;

  i2c_strap_regs dut (
    .clk(clk), .rstN(rstN), .csHigh(csHigh), .strapAlt(strapAlt),
    .sclIn(sclM), .sdaIn(sdaBus), .sdaDriveLow(sdaDriveLow)
  );

  int vecCnt = 0;
  int errCnt = 0;
  int csDriveHits = 0;
  logic [7:0] model [64];
  logic [7:0] rbuf [64];

  always @(posedge clk) if (!csHigh && sdaDriveLow) csDriveHits++;

  task automatic q();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; q(); sclM = 1'b1; q(); sdaM = 1'b0; q(); sclM = 1'b0; q();
  endtask

  task automatic busStop();
    sdaM = 1'b0; q(); sclM = 1'b1; q(); sdaM = 1'b1; q();
  endtask

  task automatic sendBits(int n, logic [7:0] b);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; q(); sclM = 1'b1; q(); q(); sclM = 1'b0; q();
    end
  endtask

  task automatic sendByte(logic [7:0] b, output logic acked);
    sendBits(8, b);
    sdaM = 1'b1; q(); sclM = 1'b1; q();
    acked = !sdaBus;
    q(); sclM = 1'b0; q();
  endtask

  task automatic recvByte(logic giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); q(); sclM = 1'b1; q(); b[i] = sdaBus; q(); sclM = 1'b0;
    end
    q(); sdaM = giveAck ? 1'b0 : 1'b1; q(); sclM = 1'b1; q(); q(); sclM = 1'b0; q();
    sdaM = 1'b1;
  endtask

  // write n bytes (seed + 13k) from index ptr; expAck says whether target should answer
  task automatic writeRegs(string tag, logic [6:0] a7, logic [7:0] ptr, int n,
                           logic [7:0] seed, logic expAck);
    logic ack;
    logic [7:0] d;
    busStart();
    sendByte({a7, 1'b0}, ack); chk({tag, " addr ack"}, {7'd0, ack}, {7'd0, expAck});
    sendByte(ptr, ack);        chk({tag, " ptr ack"},  {7'd0, ack}, {7'd0, expAck});
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(13 * k);
      sendByte(d, ack);        chk({tag, " data ack"}, {7'd0, ack}, {7'd0, expAck});
      if (expAck) model[(ptr + k) % 64] = d;
    end
    busStop();
  endtask

  task automatic readRegs(string tag, logic [6:0] a7, logic [7:0] ptr, int n, logic repStart);
    logic ack;
    logic [7:0] d;
    busStart();
    sendByte({a7, 1'b0}, ack); chk({tag, " rd addr ack"}, {7'd0, ack}, 8'd1);
    sendByte(ptr, ack);        chk({tag, " rd ptr ack"},  {7'd0, ack}, 8'd1);
    if (!repStart) busStop();
    busStart();
    sendByte({a7, 1'b1}, ack); chk({tag, " rd dir ack"},  {7'd0, ack}, 8'd1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, d);
      rbuf[k] = d;
    end
    chk({tag, " released after NACK"}, {7'd0, sdaDriveLow}, 8'd0);
    busStop();
  endtask

  task automatic expectRegs(string tag, logic [7:0] ptr, int n);
    for (int k = 0; k < n; k++) chk(tag, rbuf[k], model[(ptr + k) % 64]);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      vecCnt++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    logic ack;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (10) @(negedge clk);
    chk("R1 drive in reset", {7'd0, sdaDriveLow}, 8'd0);
    rstN = 1'b1;
    q();
    chk("R1 drive after reset", {7'd0, sdaDriveLow}, 8'd0);
    readRegs("R1", 7'h1D, 8'd0, 4, 1'b1);
    expectRegs("R1 reset value", 8'd0, 4);

    // R5: fill the whole file in four bursts
    for (int b = 0; b < 4; b++)
      writeRegs("R5", 7'h1D, 8'(b * 16), 16, 8'(b * 37 + 5), 1'b1);
    // R6: read all 64 in one burst with repeated start
    readRegs("R6", 7'h1D, 8'd0, 64, 1'b1);
    expectRegs("R6 burst read", 8'd0, 64);
    // R11: stop then start between index write and read
    readRegs("R11", 7'h1D, 8'd40, 5, 1'b0);
    expectRegs("R11 split read", 8'd40, 5);

    // R7: upper index bits ignored, wrap 63 -> 0
    writeRegs("R7", 7'h1D, 8'hFE, 3, 8'hA1, 1'b1);
    readRegs("R7", 7'h1D, 8'd62, 3, 1'b1);
    expectRegs("R7 wrap", 8'd62, 3);
    readRegs("R7", 7'h1D, 8'hC3, 2, 1'b1);
    expectRegs("R7 high bits", 8'd3, 2);

    // R3: strap low selects 0x53
    strapAlt = 1'b0; q();
    writeRegs("R3 old addr", 7'h1D, 8'd8, 2, 8'h11, 1'b0);
    writeRegs("R3 new addr", 7'h53, 8'd8, 2, 8'h77, 1'b1);
    readRegs("R3", 7'h53, 8'd8, 2, 1'b1);
    expectRegs("R3 data", 8'd8, 2);

    // R2: strap high rejects 0x53
    strapAlt = 1'b1; q();
    writeRegs("R2 alt addr", 7'h53, 8'd8, 2, 8'h22, 1'b0);
    readRegs("R2", 7'h1D, 8'd8, 2, 1'b1);
    expectRegs("R2 unchanged", 8'd8, 2);

    // R4: unknown address, trailing bytes ignored
    writeRegs("R4", 7'h2A, 8'd12, 3, 8'h5C, 1'b0);
    readRegs("R4", 7'h1D, 8'd12, 3, 1'b1);
    expectRegs("R4 unchanged", 8'd12, 3);

    // R8: disabled block ignores a well-formed write
    csHigh = 1'b0; q();
    writeRegs("R8", 7'h1D, 8'd30, 2, 8'h99, 1'b0);
    csHigh = 1'b1; q();
    chk("R8 no drive while disabled", 8'(csDriveHits), 8'd0);
    readRegs("R8", 7'h1D, 8'd30, 2, 1'b1);
    expectRegs("R8 unchanged", 8'd30, 2);

    // R9: stop mid data byte writes nothing
    busStart();
    sendByte({7'h1D, 1'b0}, ack);
    sendByte(8'd20, ack);
    sendBits(4, 8'hF0);
    busStop();
    readRegs("R9", 7'h1D, 8'd20, 1, 1'b1);
    expectRegs("R9 stop mid byte", 8'd20, 1);
    // R9: start mid address byte restarts reception
    busStart();
    sendBits(3, 8'h3A);
    busStart();
    sendByte({7'h1D, 1'b0}, ack); chk("R9 restart addr ack", {7'd0, ack}, 8'd1);
    sendByte(8'd21, ack);
    sendByte(8'h6E, ack);         chk("R9 restart data ack", {7'd0, ack}, 8'd1);
    model[21] = 8'h6E;
    busStop();
    readRegs("R9", 7'h1D, 8'd20, 2, 1'b1);
    expectRegs("R9 after restart", 8'd20, 2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule